// File: doc/BRIEF.md
# Block-Scanned Region-of-Interest Address Generator

This block generates pixel read addresses for an imager of 128 columns by 64 rows. The frame is split into rectangular blocks; the pixels inside a block are visited one per clock, and when a block is finished the block origin moves on across the array. Block width, block height, horizontal step and vertical step are programmable, so the scan can cover single pixels, the whole array, non-overlapping tiles or overlapping sliding windows.

Each emitted address carries a valid strobe. The first pixel of a block carries a start-of-block mark and the last pixel carries an end-of-block mark, so a downstream histogram can treat each block as one subimage. A one-cycle done pulse follows the last pixel of the frame. The configuration inputs are captured when a frame is started, so software may rewrite them at any time.

Top module: `roi_scan_gen`

## Requirements
- R1: After reset, and while idle, `pix_vld_o`, `sob_o`, `eob_o` and `frame_done_o` are low.
- R2: A high `start_i` while idle starts a frame; the first address, (0,0), is valid in the next cycle. Size fields are encoded as size minus one (`cfg_bw_m1_i` = width-1, `cfg_bh_m1_i` = height-1).
- R3: Inside a block, pixels are emitted one per cycle in raster order, column fastest: X = origin X + column offset, Y = origin Y + row offset.
- R4: Block origins advance in raster order: X origin grows by the horizontal step (`cfg_sx_m1_i`+1); when no further block fits in the row, X origin returns to 0 and Y origin grows by the vertical step (`cfg_sy_m1_i`+1).
- R5: Only block positions whose whole block lies inside the array are scanned; every emitted address lies inside the array.
- R6: `sob_o` is high exactly with the first pixel of each block and `eob_o` exactly with its last; a 1x1 block raises both on its single pixel.
- R7: `frame_done_o` is high for exactly one cycle, the cycle after the last pixel of the last block, with `pix_vld_o` low in that cycle.
- R8: Configuration is captured at frame start; changes to the configuration inputs during a frame do not alter that frame and apply to the next.
- R9: `start_i` asserted while a frame is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a frame when idle |
| cfg_bw_m1_i | input | XW | Block width minus one |
| cfg_bh_m1_i | input | YW | Block height minus one |
| cfg_sx_m1_i | input | XW | Horizontal block step minus one |
| cfg_sy_m1_i | input | YW | Vertical block step minus one |
| pix_vld_o | output | 1 | Address valid |
| pix_x_o | output | XW | Pixel column address |
| pix_y_o | output | YW | Pixel row address |
| sob_o | output | 1 | First pixel of a block |
| eob_o | output | 1 | Last pixel of a block |
| frame_done_o | output | 1 | One-cycle pulse after the frame's last pixel |

## Verification
The bench runs a reduced 16x8 array and compares every emitted cycle against an address stream computed arithmetically from the block counts. Single-pixel blocks show that start and end marks coincide, the whole-array block checks one-block frames, exact tiling checks the step arithmetic, and sizes with leftover columns and rows show that overrunning positions are skipped rather than clipped. Overlapping one-pixel steps separate step from size, and a frame with mid-frame configuration writes and a second start pulse shows that the snapshot and the busy guard hold, with the following frame confirming the new setting takes effect.

// File: rtl/roi_scan_pkg.sv
package roi_scan_pkg;
  localparam int unsigned ROI_COLS_DEF = 128;
  localparam int unsigned ROI_ROWS_DEF = 64;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_st_e;
endpackage

// File: rtl/roi_cfg_reg.sv
module roi_cfg_reg #(
  parameter int unsigned XW = 7,
  parameter int unsigned YW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          busy_i,
  input  logic [XW-1:0] bw_m1_i,
  input  logic [YW-1:0] bh_m1_i,
  input  logic [XW-1:0] sx_m1_i,
  input  logic [YW-1:0] sy_m1_i,
  output logic [XW-1:0] bw_m1_o,
  output logic [YW-1:0] bh_m1_o,
  output logic [XW:0]   sx_o,
  output logic [YW:0]   sy_o
);
  logic [XW-1:0] bw_q, sxm_q;
  logic [YW-1:0] bh_q, sym_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bw_q  <= '0;
      bh_q  <= '0;
      sxm_q <= '0;
      sym_q <= '0;
    end else if (load_i) begin
      bw_q  <= bw_m1_i;
      bh_q  <= bh_m1_i;
      sxm_q <= sx_m1_i;
      sym_q <= sy_m1_i;
    end
  end

  assign bw_m1_o = bw_q;
  assign bh_m1_o = bh_q;
  assign sx_o    = {1'b0, sxm_q} + 1'b1;
  assign sy_o    = {1'b0, sym_q} + 1'b1;

  // R8: snapshot frozen while a frame runs
  a_r8_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> ($stable(bw_q) && $stable(bh_q) && $stable(sxm_q) && $stable(sym_q)))
    else $error("a_r8_cfg_frozen");
endmodule

// File: rtl/roi_axis_cnt.sv
// Generic stepping counter: advances by step_i, wraps to 0 when the next
// value plus span_m1_i would pass limit_i.
module roi_axis_cnt #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W:0]   step_i,
  input  logic [W-1:0] span_m1_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] val_o,
  output logic         last_o
);
  localparam int unsigned SW = W + 2;

  logic [W-1:0]  val_q;
  logic [SW-1:0] nxt_end;

  assign nxt_end = SW'(val_q) + SW'(step_i) + SW'(span_m1_i);
  assign last_o  = nxt_end > SW'(limit_i);
  assign val_o   = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          val_q <= '0;
    else if (clr_i)       val_q <= '0;
    else if (adv_i) begin
      if (last_o)         val_q <= '0;
      else                val_q <= val_q + step_i[W-1:0];
    end
  end
endmodule

// File: rtl/roi_scan_gen.sv
module roi_scan_gen
  import roi_scan_pkg::*;
#(
  parameter int unsigned COLS = ROI_COLS_DEF,
  parameter int unsigned ROWS = ROI_ROWS_DEF,
  localparam int unsigned XW = $clog2(COLS),
  localparam int unsigned YW = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [XW-1:0] cfg_bw_m1_i,
  input  logic [YW-1:0] cfg_bh_m1_i,
  input  logic [XW-1:0] cfg_sx_m1_i,
  input  logic [YW-1:0] cfg_sy_m1_i,
  output logic          pix_vld_o,
  output logic [XW-1:0] pix_x_o,
  output logic [YW-1:0] pix_y_o,
  output logic          sob_o,
  output logic          eob_o,
  output logic          frame_done_o
);
  localparam logic [XW-1:0] X_LIM = XW'(COLS - 1);
  localparam logic [YW-1:0] Y_LIM = YW'(ROWS - 1);

  scan_st_e st_q;
  logic     busy, accept, frame_end, done_q;

  logic [XW-1:0] bw_m1;
  logic [YW-1:0] bh_m1;
  logic [XW:0]   sx;
  logic [YW:0]   sy;

  logic [XW-1:0] pc_val, bx_val;
  logic [YW-1:0] pr_val, by_val;
  logic          pc_last, pr_last, bx_last, by_last;
  logic          pc_adv, pr_adv, bx_adv, by_adv;

  assign busy   = (st_q == ST_SCAN);
  assign accept = start_i && !busy;

  roi_cfg_reg #(.XW(XW), .YW(YW)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .busy_i  (busy),
    .bw_m1_i (cfg_bw_m1_i),
    .bh_m1_i (cfg_bh_m1_i),
    .sx_m1_i (cfg_sx_m1_i),
    .sy_m1_i (cfg_sy_m1_i),
    .bw_m1_o (bw_m1),
    .bh_m1_o (bh_m1),
    .sx_o    (sx),
    .sy_o    (sy)
  );

  // advance chain: column -> row -> block X -> block Y
  assign pc_adv    = busy;
  assign pr_adv    = pc_adv && pc_last;
  assign bx_adv    = pr_adv && pr_last;
  assign by_adv    = bx_adv && bx_last;
  assign frame_end = by_adv && by_last;

  roi_axis_cnt #(.W(XW)) u_pix_col (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (accept), .adv_i (pc_adv),
    .step_i ((XW+1)'(1)), .span_m1_i ('0), .limit_i (bw_m1),
    .val_o (pc_val), .last_o (pc_last)
  );

  roi_axis_cnt #(.W(YW)) u_pix_row (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (accept), .adv_i (pr_adv),
    .step_i ((YW+1)'(1)), .span_m1_i ('0), .limit_i (bh_m1),
    .val_o (pr_val), .last_o (pr_last)
  );

  roi_axis_cnt #(.W(XW)) u_blk_x (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (accept), .adv_i (bx_adv),
    .step_i (sx), .span_m1_i (bw_m1), .limit_i (X_LIM),
    .val_o (bx_val), .last_o (bx_last)
  );

  roi_axis_cnt #(.W(YW)) u_blk_y (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (accept), .adv_i (by_adv),
    .step_i (sy), .span_m1_i (bh_m1), .limit_i (Y_LIM),
    .val_o (by_val), .last_o (by_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      done_q <= frame_end;
      if (accept)         st_q <= ST_SCAN;
      else if (frame_end) st_q <= ST_IDLE;
    end
  end

  assign pix_vld_o    = busy;
  assign pix_x_o      = bx_val + pc_val;
  assign pix_y_o      = by_val + pr_val;
  assign sob_o        = busy && (pc_val == '0) && (pr_val == '0);
  assign eob_o        = busy && pc_last && pr_last;
  assign frame_done_o = done_q;

  a_r6_marks_with_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sob_o || eob_o) |-> pix_vld_o) else $error("a_r6_marks_with_vld");

  a_r6_sob_after_eob: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_vld_o && $past(pix_vld_o) && $past(eob_o)) |-> sob_o) else $error("a_r6_sob_after_eob");

  a_r5_in_array: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_vld_o |-> ((32'(pix_x_o) < COLS) && (32'(pix_y_o) < ROWS))) else $error("a_r5_in_array");

  a_r3_col_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_vld_o && $past(pix_vld_o) && !$past(eob_o) && (pix_y_o == $past(pix_y_o)))
      |-> (pix_x_o == XW'($past(pix_x_o) + 1'b1))) else $error("a_r3_col_step");

  a_r7_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> ($past(eob_o) && !pix_vld_o)) else $error("a_r7_done_after_last");

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o) else $error("a_r7_done_single");
endmodule

// File: tb/sim_roi_scan_gen.sv
module sim_roi_scan_gen;
  localparam int COLS = 16;
  localparam int ROWS = 8;
  localparam int XW = $clog2(COLS);
  localparam int YW = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [XW-1:0] bw_m1 = '0, sx_m1 = '0;
  logic [YW-1:0] bh_m1 = '0, sy_m1 = '0;
  logic vld, sob, eob, done;
  logic [XW-1:0] px;
  logic [YW-1:0] py;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  roi_scan_gen #(.COLS(COLS), .ROWS(ROWS)) u0 (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start),
    .cfg_bw_m1_i (bw_m1), .cfg_bh_m1_i (bh_m1),
    .cfg_sx_m1_i (sx_m1), .cfg_sy_m1_i (sy_m1),
    .pix_vld_o (vld), .pix_x_o (px), .pix_y_o (py),
    .sob_o (sob), .eob_o (eob), .frame_done_o (done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one frame, every cycle compared against the arithmetic model
  task automatic run_frame(input int bw, input int bh, input int sx, input int sy,
                           input bit perturb);
    int nbx, nby, idx, nx, ny;
    bit es, ee;
    nbx = (COLS - bw) / sx + 1;
    nby = (ROWS - bh) / sy + 1;
    @(negedge clk);
    bw_m1 = XW'(bw - 1); bh_m1 = YW'(bh - 1);
    sx_m1 = XW'(sx - 1); sy_m1 = YW'(sy - 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx = 0;
    for (int byi = 0; byi < nby; byi++)
      for (int bxi = 0; bxi < nbx; bxi++)
        for (int r = 0; r < bh; r++)
          for (int c = 0; c < bw; c++) begin
            if (idx > 0) @(negedge clk);
            nx = bxi * sx + c;
            ny = byi * sy + r;
            es = (r == 0) && (c == 0);
            ee = (r == bh - 1) && (c == bw - 1);
            chk(perturb ? "R8 R9 vld" : "R2 R3 vld", int'(vld), 1);
            chk(perturb ? "R8 R9 x" : "R3 R4 R5 x", int'(px), nx);
            chk(perturb ? "R8 R9 y" : "R3 R4 R5 y", int'(py), ny);
            chk("R6 sob", int'(sob), int'(es));
            chk("R6 eob", int'(eob), int'(ee));
            if (perturb && idx == 2) begin
              bw_m1 = XW'(0); bh_m1 = YW'(0); sx_m1 = XW'(0); sy_m1 = YW'(0);
              start = 1'b1;
            end
            if (perturb && idx == 3) start = 1'b0;
            idx++;
          end
    @(negedge clk);
    chk("R7 done", int'(done), 1);
    chk("R7 vld low", int'(vld), 0);
    @(negedge clk);
    chk("R7 done single", int'(done), 0);
    chk("R9 no restart", int'(vld), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset vld", int'(vld), 0);
    chk("R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R1 idle vld", int'(vld), 0);
      chk("R1 idle marks", int'(sob | eob | done), 0);
    end
    run_frame(1, 1, 1, 1, 1'b0);     // R6 single pixel blocks
    run_frame(COLS, ROWS, 1, 1, 1'b0); // whole array, one block
    run_frame(4, 2, 4, 2, 1'b0);     // exact tiling
    run_frame(5, 3, 4, 3, 1'b0);     // R5 overrun positions skipped
    run_frame(3, 2, 1, 1, 1'b0);     // overlapping windows
    run_frame(COLS, 1, COLS, 1, 1'b0);
    run_frame(2, ROWS, 7, 5, 1'b0);
    run_frame(4, 4, 2, 2, 1'b1);     // R8 R9 mid-frame writes and start
    run_frame(3, 3, 3, 3, 1'b0);     // R8 new config applies next frame
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule